// File: doc/BRIEF.md
# Dual-Port Synchronous FIFO with Indexed Level Flags

This block is a single-clock first-in first-out buffer. In one clock cycle it takes up to two new items and hands out up to two stored items. Each side has two ports. Port 0 always ranks ahead of port 1. On the write side, port 0's item is stored first. On the read side, port 0 gets the oldest entry, and port 1 gets the entry after it. If port 0 is not reading, port 1 gets the oldest entry. The stored-entry count changes by the net amount each cycle: items written minus items read.

Each requester needs to know whether its own slot can be served, so the block gives it an indexed flag. Empty flag `i` says that exactly `i` entries are held. Full flag `i` says that exactly `i` free slots remain. The flags are decoded from the registered count. A separate error output reports a read request made while the buffer was empty one cycle earlier.

Requests the buffer cannot serve are dropped. Dropped requests do not move the pointers and do not change the count. A read port that is not granted drives zero on its data output, so unwritten storage is never shown.

Top module: `dual_port_fifo`

## Requirements
- R1: After reset the count and both pointers are zero, so `empty_flag` = 2'b01, `full_flag` = 2'b00, and the first read request raises `rd_empty_err`.
- R2: Items come out in the order they were accepted. Of two items accepted in the same cycle, the port-0 item is older than the port-1 item.
- R3: A granted read on port 0 returns the oldest entry. A granted read on port 1 returns the next entry if port 0 also reads, and the oldest entry otherwise. Port 1 is never granted a read when port 0 requests and is refused.
- R4: On each clock edge the count becomes its old value plus the writes granted minus the reads granted. Each of these is 0, 1 or 2.
- R5: `empty_flag[i]` (i = 0, 1) is 1 exactly when the registered count equals i.
- R6: `full_flag[i]` (i = 0, 1) is 1 exactly when the registered count equals DEPTH minus i.
- R7: Free space is taken from the count at the start of the cycle, so a read in the same cycle does not make room. A write that finds no free slot, after port 0's write has been counted, is dropped. It leaves the count and the stored data unchanged.
- R8: A read that finds no stored entry, after port 0's read has been counted, is refused. It drives zero on its data output and leaves the count unchanged.
- R9: `rd_empty_err` is 1 in a cycle exactly when a read is requested on either port and the count was zero in the previous cycle.
- R10: Both pointers wrap modulo DEPTH, including when DEPTH is not a power of two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr0_vld | input | 1 | Write request, port 0 (first in order) |
| wr0_data | input | WIDTH | Write data, port 0 |
| wr1_vld | input | 1 | Write request, port 1 |
| wr1_data | input | WIDTH | Write data, port 1 |
| rd0_req | input | 1 | Read request, port 0 (first in order) |
| rd0_data | output | WIDTH | Read data, port 0; zero when not granted |
| rd1_req | input | 1 | Read request, port 1 |
| rd1_data | output | WIDTH | Read data, port 1; zero when not granted |
| empty_flag | output | 2 | Bit i set when exactly i entries are held |
| full_flag | output | 2 | Bit i set when exactly i free slots remain |
| rd_empty_err | output | 1 | Read requested while the buffer was empty in the previous cycle |

## Verification
The assertions assume that DEPTH is at least 4. With that depth, an empty-side flag and a full-side flag can never be set together. The assertions also assume that every request input is 0 or 1 in each cycle after reset, and never X. The bench changes its inputs only on falling edges and drives every request with a known level in every cycle. The stimulus deliberately runs past both limits: it overfills, requests reads on an empty buffer, and reads while full. This lets the refusal checks in the assertions fire, while the inputs stay within the legal encoding.

// File: rtl/dpf_pkg.sv
package dpf_pkg;

  // Per-cycle acceptance decisions for the four ports.
  typedef struct packed {
    logic w0;
    logic w1;
    logic r0;
    logic r1;
  } dpf_grant_t;

endpackage

// File: rtl/dpf_ctrl.sv
module dpf_ctrl
  import dpf_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int PW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr0_vld,
  input  logic          wr1_vld,
  input  logic          rd0_req,
  input  logic          rd1_req,
  output dpf_grant_t    gnt,
  output logic [PW-1:0] wr_addr0,
  output logic [PW-1:0] wr_addr1,
  output logic [PW-1:0] rd_addr0,
  output logic [PW-1:0] rd_addr1,
  output logic [CW-1:0] count_q
);

  localparam logic [CW:0] DEP_X = (CW + 1)'(DEPTH);
  localparam logic [PW:0] DEP_P = (PW + 1)'(DEPTH);

  logic [PW-1:0] wr_ptr_q, wr_ptr_d;
  logic [PW-1:0] rd_ptr_q, rd_ptr_d;
  logic [CW-1:0] count_d;
  logic [CW:0]   cnt_x;
  logic [1:0]    n_wr, n_rd;
  logic          upd_en;

  // Advance a pointer by k slots, wrapping modulo DEPTH.
  function automatic logic [PW-1:0] adv(input logic [PW-1:0] p, input logic [1:0] k);
    logic [PW:0] s;
    s = {1'b0, p} + {{(PW - 1){1'b0}}, k};
    if (s >= DEP_P) s = s - DEP_P;
    return s[PW-1:0];
  endfunction

  // Grant decisions: port 0 first, both sides judged on the start-of-cycle count.
  always_comb begin
    cnt_x  = {1'b0, count_q};
    gnt.w0 = wr0_vld && (cnt_x < DEP_X);
    gnt.w1 = wr1_vld && (gnt.w0 ? (cnt_x + 2 <= DEP_X) : (cnt_x < DEP_X));
    gnt.r0 = rd0_req && (cnt_x != '0);
    gnt.r1 = rd1_req && (gnt.r0 ? (cnt_x >= 2) : (cnt_x != '0));
    n_wr   = {1'b0, gnt.w0} + {1'b0, gnt.w1};
    n_rd   = {1'b0, gnt.r0} + {1'b0, gnt.r1};
  end

  // Next-state values.
  always_comb begin
    wr_ptr_d = adv(wr_ptr_q, n_wr);
    rd_ptr_d = adv(rd_ptr_q, n_rd);
    count_d  = CW'(cnt_x + {{(CW - 1){1'b0}}, n_wr} - {{(CW - 1){1'b0}}, n_rd});
    upd_en   = (n_wr != 2'd0) || (n_rd != 2'd0);
  end

  assign wr_addr0 = wr_ptr_q;
  assign wr_addr1 = adv(wr_ptr_q, {1'b0, gnt.w0});
  assign rd_addr0 = rd_ptr_q;
  assign rd_addr1 = adv(rd_ptr_q, {1'b0, gnt.r0});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else if (upd_en) begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      count_q  <= count_d;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, count_q} <= DEP_X); // R7
  AST_FULL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, count_q} == DEP_X) |-> !(gnt.w0 || gnt.w1)); // R7
  AST_EMPTY_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (count_q == '0) |-> !(gnt.r0 || gnt.r1)); // R8
  AST_READ_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt.r1 && rd0_req) |-> gnt.r0); // R3
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (n_wr == n_rd) |=> $stable(count_q)); // R4
  AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, wr_ptr_q} < DEP_P) && ({1'b0, rd_ptr_q} < DEP_P)); // R10

endmodule

// File: rtl/dpf_store.sv
module dpf_store #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 8,
  localparam int PW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we0,
  input  logic [PW-1:0]    wa0,
  input  logic [WIDTH-1:0] wd0,
  input  logic             we1,
  input  logic [PW-1:0]    wa1,
  input  logic [WIDTH-1:0] wd1,
  input  logic [PW-1:0]    ra0,
  input  logic [PW-1:0]    ra1,
  output logic [WIDTH-1:0] rq0,
  output logic [WIDTH-1:0] rq1
);

  logic [WIDTH-1:0] mem [DEPTH];

  // Storage carries no reset; the read gating in the top hides unwritten slots.
  always_ff @(posedge clk) begin
    if (we0) mem[wa0] <= wd0;
    if (we1) mem[wa1] <= wd1;
  end

  assign rq0 = mem[ra0];
  assign rq1 = mem[ra1];

endmodule

// File: rtl/dpf_status.sv
module dpf_status #(
  parameter int DEPTH = 8,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] count_q,
  input  logic          rd0_req,
  input  logic          rd1_req,
  output logic [1:0]    empty_flag,
  output logic [1:0]    full_flag,
  output logic          rd_empty_err
);

  logic was_empty_q, was_empty_d;

  for (genvar i = 0; i < 2; i++) begin : g_lvl
    assign empty_flag[i] = (count_q == CW'(i));
    assign full_flag[i]  = (count_q == CW'(DEPTH - i));
  end

  assign was_empty_d  = (count_q == '0);
  assign rd_empty_err = (rd0_req || rd1_req) && was_empty_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) was_empty_q <= 1'b1;
    else        was_empty_q <= was_empty_d;
  end

  AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !((empty_flag != 2'b00) && (full_flag != 2'b00))); // R5
  AST_FLAG_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(empty_flag) && $onehot0(full_flag)); // R6
  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_empty_err |-> (rd0_req || rd1_req)); // R9
  AST_ERR_HISTORY: assert property (@(posedge clk) disable iff (!rst_n)
    (!empty_flag[0] && !rd_empty_err && rd0_req) |=> !(rd_empty_err && !rd0_req && !rd1_req)); // R9

endmodule

// File: rtl/dual_port_fifo.sv
module dual_port_fifo
  import dpf_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int DEPTH = 8,
  localparam int PW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr0_vld,
  input  logic [WIDTH-1:0] wr0_data,
  input  logic             wr1_vld,
  input  logic [WIDTH-1:0] wr1_data,
  input  logic             rd0_req,
  output logic [WIDTH-1:0] rd0_data,
  input  logic             rd1_req,
  output logic [WIDTH-1:0] rd1_data,
  output logic [1:0]       empty_flag,
  output logic [1:0]       full_flag,
  output logic             rd_empty_err
);

  dpf_grant_t       gnt;
  logic [PW-1:0]    wa0, wa1, ra0, ra1;
  logic [CW-1:0]    count_q;
  logic [WIDTH-1:0] rq0, rq1;

  dpf_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr0_vld  (wr0_vld),
    .wr1_vld  (wr1_vld),
    .rd0_req  (rd0_req),
    .rd1_req  (rd1_req),
    .gnt      (gnt),
    .wr_addr0 (wa0),
    .wr_addr1 (wa1),
    .rd_addr0 (ra0),
    .rd_addr1 (ra1),
    .count_q  (count_q)
  );

  dpf_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_store (
    .clk (clk),
    .we0 (gnt.w0),
    .wa0 (wa0),
    .wd0 (wr0_data),
    .we1 (gnt.w1),
    .wa1 (wa1),
    .wd1 (wr1_data),
    .ra0 (ra0),
    .ra1 (ra1),
    .rq0 (rq0),
    .rq1 (rq1)
  );

  dpf_status #(.DEPTH(DEPTH)) u_status (
    .clk          (clk),
    .rst_n        (rst_n),
    .count_q      (count_q),
    .rd0_req      (rd0_req),
    .rd1_req      (rd1_req),
    .empty_flag   (empty_flag),
    .full_flag    (full_flag),
    .rd_empty_err (rd_empty_err)
  );

  // Refused reads show zero, never raw storage.
  assign rd0_data = gnt.r0 ? rq0 : '0;
  assign rd1_data = gnt.r1 ? rq1 : '0;

  AST_GATED_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (empty_flag[0]) |-> (rd0_data == '0) && (rd1_data == '0)); // R8

endmodule

// File: tb/sim_dual_port_fifo.sv
module sim_dual_port_fifo;

  localparam int W = 8;
  localparam int D = 6;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         wr0_vld, wr1_vld, rd0_req, rd1_req;
  logic [W-1:0] wr0_data, wr1_data, rd0_data, rd1_data;
  logic [1:0]   empty_flag, full_flag;
  logic         rd_empty_err;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 0;

  // Scoreboard state: queue of expected items plus previous-cycle empty status.
  logic [W-1:0] sb[$];
  bit           prev_empty;

  always #5 clk = ~clk;

  dual_port_fifo #(.WIDTH(W), .DEPTH(D)) u0 (
    .clk(clk), .rst_n(rst_n),
    .wr0_vld(wr0_vld), .wr0_data(wr0_data),
    .wr1_vld(wr1_vld), .wr1_data(wr1_data),
    .rd0_req(rd0_req), .rd0_data(rd0_data),
    .rd1_req(rd1_req), .rd1_data(rd1_data),
    .empty_flag(empty_flag), .full_flag(full_flag),
    .rd_empty_err(rd_empty_err)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // One cycle: drive inputs, compare outputs against the scoreboard, then update it.
  task automatic cyc(input string tag, input bit w0, input logic [W-1:0] d0,
                     input bit w1, input logic [W-1:0] d1, input bit r0, input bit r1);
    int cnt;
    bit g0, g1, wg0, wg1;
    logic [W-1:0] e0, e1;
    @(negedge clk);
    wr0_vld = w0; wr0_data = d0; wr1_vld = w1; wr1_data = d1;
    rd0_req = r0; rd1_req = r1;
    #1;
    cnt = sb.size();
    g0  = r0 && cnt >= 1;
    g1  = r1 && cnt >= (g0 ? 2 : 1);
    e0  = g0 ? sb[0] : '0;
    e1  = g1 ? (g0 ? sb[1] : sb[0]) : '0;
    wg0 = w0 && (D - cnt) >= 1;
    wg1 = w1 && (D - cnt) >= (wg0 ? 2 : 1);
    chk({tag, " R2 R3 R8 rd0_data"}, 32'(rd0_data), 32'(e0));
    chk({tag, " R2 R3 R8 rd1_data"}, 32'(rd1_data), 32'(e1));
    chk({tag, " R4 R5 empty_flag"}, 32'(empty_flag), {30'd0, cnt == 1, cnt == 0});
    chk({tag, " R4 R6 full_flag"}, 32'(full_flag), {30'd0, cnt == D - 1, cnt == D});
    chk({tag, " R9 rd_empty_err"}, 32'(rd_empty_err), 32'((r0 || r1) && prev_empty));
    prev_empty = (cnt == 0);
    if (g0) void'(sb.pop_front());
    if (g1) void'(sb.pop_front());
    if (wg0) sb.push_back(d0);
    if (wg1) sb.push_back(d1);
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    wr0_vld = 0; wr1_vld = 0; rd0_req = 0; rd1_req = 0;
    wr0_data = '0; wr1_data = '0;
    prev_empty = 1;
    #23;
    chk("R1 reset empty_flag", 32'(empty_flag), 32'd1);
    chk("R1 reset full_flag", 32'(full_flag), 32'd0);
    chk("R1 reset rd_empty_err", 32'(rd_empty_err), 32'd0);
    rst_n = 1'b1;
    cyc("R1 R8 read after reset", 0, 0, 0, 0, 1, 1);
    cyc("R2 single write", 1, 8'hA1, 0, 0, 0, 0);
    cyc("R2 dual write", 1, 8'hB2, 1, 8'hC3, 0, 0);
    cyc("R3 port1 only read", 0, 0, 0, 0, 0, 1);
    cyc("R3 R4 dual read with dual write", 1, 8'hD4, 1, 8'hE5, 1, 1);
    cyc("R7 fill", 1, 8'h11, 1, 8'h22, 0, 0);
    cyc("R7 fill to full", 1, 8'h33, 1, 8'h44, 0, 0);
    cyc("R7 write when full", 1, 8'h55, 1, 8'h66, 0, 0);
    cyc("R7 read while full no room", 1, 8'h77, 0, 0, 1, 0);
    cyc("R7 one slot dual write", 1, 8'h88, 1, 8'h99, 0, 0);
    cyc("R3 drain", 0, 0, 0, 0, 1, 1);
    cyc("R3 drain", 0, 0, 0, 0, 1, 1);
    cyc("R3 drain", 0, 0, 0, 0, 1, 0);
    cyc("R8 one entry dual read", 0, 0, 0, 0, 1, 1);
    cyc("R9 read on empty", 0, 0, 0, 0, 0, 1);
    cyc("R9 write after empty", 1, 8'h5A, 0, 0, 1, 0);
    cyc("R9 read after refill", 0, 0, 0, 0, 1, 0);
    for (int i = 0; i < 80; i++) begin
      cyc("R10 wrap stream", (i % 3) != 0, 8'(i * 7 + 1), (i % 4) < 2, 8'(i * 5 + 3),
          (i % 5) != 1, (i % 2) == 0);
    end
    for (int i = 0; i < 4; i++) cyc("R10 final drain", 0, 0, 0, 0, 1, 1);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule